// File: doc/BRIEF.md
# Dual-Clock Gauging Counter

This block measures one window of time in two clock domains at once. One domain is a slow reference of about 32 kHz and the other is a fast clock. Each domain reaches the block as a single-cycle tick enable in the system clock domain. Software opens the window by setting bit 0 of the control register and closes it by clearing that bit. While the window is open, each of two counters adds one on every cycle in which its tick enable is high.

When the window closes, both counts are captured into result registers. Each result is read as a low half and a high half over a 16-bit register bus. Per-counter overflow flags and a "done" flag are set in a status register, and the interrupt output goes high. A read of the status register returns its value, clears it to zero and drops the interrupt.

The count width is a parameter, `CNT_W`, with a default of 32. Each result half is `CNT_W/2` bits wide and is zero-extended onto the 16-bit bus. The block is used to calibrate the fast clock against the slow one. A typical sequence opens the window, waits, closes it, takes the interrupt, reads the four halves, and divides one count by the other.

Top module: `dual_clock_gauge`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: A control write that moves bit 0 from 0 to 1 clears both counters and opens the window. While the window is open, the slow counter adds one for each cycle with `ref_tick` high and the fast counter adds one for each cycle with `fast_tick` high. Ticks in the cycle of the opening write or the closing write are not counted.
- R3: A control write that moves bit 0 from 1 to 0 closes the window and captures both counts. The slow count is read as its low half at address 0x00 and its high half at 0x04. The fast count is read as its low half at 0x08 and its high half at 0x0C.
- R4: Closing the window sets status bit 0 (done) and drives `irq` high from the next cycle on.
- R5: A window holding at least 2^CNT_W ticks of a domain sets that domain's overflow flag. The slow overflow is status bit 2 and the fast overflow is status bit 1. The captured count is the tick total modulo 2^CNT_W.
- R6: A read of the status register at 0x14 returns its current value, then clears it to zero and drops `irq`.
- R7: Writes to 0x00, 0x04, 0x08, 0x0C and 0x14 are ignored. The results and the status read back unchanged.
- R8: A control write that leaves bit 0 unchanged only stores the written value, which reads back at 0x10. It neither restarts nor stops the counters, and it raises no interrupt.
- R9: Captured results stay unchanged after the window closes until the next close, whatever the tick inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for read-to-clear) |
| addr | input | 8 | Byte address of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| ref_tick | input | 1 | Tick enable of the slow reference domain |
| fast_tick | input | 1 | Tick enable of the fast domain |
| irq | output | 1 | Gauging-done interrupt |

## Verification
The bench sweeps window lengths and tick periods in a small configuration (`CNT_W`=8). This includes windows that cross 2^CNT_W ticks, so the modulo result and the overflow flags are both exercised. A design that saturated instead of wrapping, or swapped the two flag bits, would return wrong halves or a wrong status value. A write that re-sets bit 0 in the middle of a window would, if treated as a start, wipe the earlier ticks from the final count. The bench also writes to every read-only address, and a design that let those writes through would show corrupted results. Finally, the bench reads the status register twice in a row, so an interrupt that survived the read-to-clear would be seen.

// File: rtl/gauge_pkg.sv
package gauge_pkg;
  localparam logic [7:0] A_REF_LO = 8'h00;
  localparam logic [7:0] A_REF_HI = 8'h04;
  localparam logic [7:0] A_FST_LO = 8'h08;
  localparam logic [7:0] A_FST_HI = 8'h0C;
  localparam logic [7:0] A_CTRL   = 8'h10;
  localparam logic [7:0] A_STAT   = 8'h14;

  localparam int ST_DONE = 0;
  localparam int ST_FOVF = 1;
  localparam int ST_ROVF = 2;
  localparam int ST_W    = 3;
  localparam int BUS_W   = 16;
  localparam int NUM_DOM = 2;
endpackage

// File: rtl/gauge_tick_counter.sv
module gauge_tick_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam int ACC_W = CNT_W + 1;

  logic [ACC_W-1:0] acc;

  // Low part wraps; the extra top bit becomes sticky once the low part rolls over.
  function automatic logic [ACC_W-1:0] bump(input logic [ACC_W-1:0] v);
    logic [CNT_W-1:0] low;
    low  = v[CNT_W-1:0] + 1'b1;
    bump = {v[CNT_W] | (&v[CNT_W-1:0]), low};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)           acc <= '0;
    else if (clear)       acc <= '0;
    else if (run && tick) acc <= bump(acc);
  end

  assign count = acc[CNT_W-1:0];
  assign ovf   = acc[CNT_W];
endmodule

// File: rtl/gauge_status.sv
module gauge_status
  import gauge_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop_evt,
  input  logic            ref_ovf,
  input  logic            fst_ovf,
  input  logic            rd_clr,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic [ST_W-1:0] set_bits;

  always_comb begin
    set_bits = '0;
    if (stop_evt) begin
      set_bits[ST_DONE] = 1'b1;
      set_bits[ST_FOVF] = fst_ovf;
      set_bits[ST_ROVF] = ref_ovf;
    end
  end

  // A new result wins over a simultaneous clearing read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (rd_clr ? '0 : status) | set_bits;
      irq    <= stop_evt ? 1'b1 : (rd_clr ? 1'b0 : irq);
    end
  end
endmodule

// File: rtl/dual_clock_gauge.sv
module dual_clock_gauge
  import gauge_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        ref_tick,
  input  logic        fast_tick,
  output logic        irq
);
  localparam int HALF_W = CNT_W / 2;

  logic [BUS_W-1:0] ctrl;
  logic             wr_ctrl, start_evt, stop_evt, rd_clr;
  logic [NUM_DOM-1:0] tick_v, ovf_v;
  logic [CNT_W-1:0]   cnt_v [NUM_DOM];
  logic [CNT_W-1:0]   lat_ref, lat_fst;
  logic [CNT_W-1:0]   cnt_ref, cnt_fst;
  logic [ST_W-1:0]    status;

  assign wr_ctrl   = wr_en && (addr == A_CTRL);
  assign start_evt = wr_ctrl && !ctrl[0] && wdata[0];
  assign stop_evt  = wr_ctrl && ctrl[0] && !wdata[0];
  assign rd_clr    = rd_en && (addr == A_STAT);
  assign tick_v    = {fast_tick, ref_tick};

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= wdata;
  end

  // Index 0 is the slow reference domain, index 1 the fast domain.
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    gauge_tick_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (start_evt),
      .run   (ctrl[0]),
      .tick  (tick_v[d]),
      .count (cnt_v[d]),
      .ovf   (ovf_v[d])
    );
  end

  assign cnt_ref = cnt_v[0];
  assign cnt_fst = cnt_v[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_ref <= '0;
      lat_fst <= '0;
    end else if (stop_evt) begin
      lat_ref <= cnt_ref;
      lat_fst <= cnt_fst;
    end
  end

  gauge_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_evt (stop_evt),
    .ref_ovf  (ovf_v[0]),
    .fst_ovf  (ovf_v[1]),
    .rd_clr   (rd_clr),
    .status   (status),
    .irq      (irq)
  );

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_REF_LO: rdata[HALF_W-1:0] = lat_ref[HALF_W-1:0];
      A_REF_HI: rdata[HALF_W-1:0] = lat_ref[CNT_W-1:HALF_W];
      A_FST_LO: rdata[HALF_W-1:0] = lat_fst[HALF_W-1:0];
      A_FST_HI: rdata[HALF_W-1:0] = lat_fst[CNT_W-1:HALF_W];
      A_CTRL:   rdata = ctrl;
      A_STAT:   rdata[ST_W-1:0] = status;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gauge_checker.sv
module gauge_checker
  import gauge_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       addr,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             irq,
  input logic [ST_W-1:0]  status,
  input logic [CNT_W-1:0] lat_ref,
  input logic [CNT_W-1:0] lat_fst,
  input logic [CNT_W-1:0] cnt_ref,
  input logic [CNT_W-1:0] cnt_fst
);
  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (cnt_ref == '0) && (cnt_fst == '0));

  assert_done_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> irq && status[ST_DONE]);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_STAT && !stop_evt) |=> !irq && (status == '0));

  assert_ro_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && addr != A_CTRL) |=> $stable(status) && $stable(lat_ref) && $stable(lat_fst));

  assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_evt |=> $stable(lat_ref) && $stable(lat_fst));
endmodule

bind dual_clock_gauge gauge_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .irq       (irq),
  .status    (status),
  .lat_ref   (lat_ref),
  .lat_fst   (lat_fst),
  .cnt_ref   (cnt_ref),
  .cnt_fst   (cnt_fst)
);

// File: tb/sim_dual_clock_gauge.sv
module sim_dual_clock_gauge;
  localparam int CW   = 8;
  localparam int HW   = CW / 2;
  localparam int MODV = 1 << CW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ref_tick = 1'b0, fast_tick = 1'b0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  dual_clock_gauge #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ref_tick(ref_tick), .fast_tick(fast_tick), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    ref_tick = 0; fast_tick = 0;
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output int v);
    @(negedge clk);
    ref_tick = 0; fast_tick = 0;
    rd_en = 1; addr = a;
    #1 v = int'(rdata);
    @(negedge clk);
    rd_en = 0;
  endtask

  // Drives ticks for n cycles; a period of 0 means never.
  task automatic drive_ticks(input int n, input int pr, input int pf,
                             inout int nr, inout int nf);
    for (int i = 0; i < n; i++) begin
      ref_tick  = (pr != 0) && (i % pr == 0);
      fast_tick = (pf != 0) && (i % pf == 0);
      nr += int'(ref_tick);
      nf += int'(fast_tick);
      @(negedge clk);
    end
    ref_tick = 0; fast_tick = 0;
  endtask

  task automatic check_results(input string req, input int nr, input int nf);
    int v;
    bus_read(8'h00, v); check({req, " slow lo"}, v, (nr % MODV) % (1 << HW));
    bus_read(8'h04, v); check({req, " slow hi"}, v, (nr % MODV) >> HW);
    bus_read(8'h08, v); check({req, " fast lo"}, v, (nf % MODV) % (1 << HW));
    bus_read(8'h0C, v); check({req, " fast hi"}, v, (nf % MODV) >> HW);
  endtask

  task automatic run_case(input int n, input int pr, input int pf);
    int nr = 0, nf = 0, v, exp_st;
    bus_write(8'h10, 16'h0001);
    @(negedge clk);
    drive_ticks(n, pr, pf, nr, nf);
    bus_write(8'h10, 16'h0000);
    check("R4 irq after close", int'(irq), 1);
    check_results("R3 R2 R5", nr, nf);
    exp_st = 1 + ((nf >= MODV) ? 2 : 0) + ((nr >= MODV) ? 4 : 0);
    bus_read(8'h14, v); check("R5 R4 status", v, exp_st);
    check("R6 irq dropped", int'(irq), 0);
    bus_read(8'h14, v); check("R6 status cleared", v, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, nr, nf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", int'(irq), 0);
    for (int a = 0; a <= 8'h14; a += 4) begin
      bus_read(8'(a), v); check("R1 reset reg", v, 0);
    end

    // R2 R3 R5 sweep of lengths and tick periods
    for (int n = 1; n <= 41; n += 8)
      for (int p = 1; p <= 4; p++)
        run_case(n, p, 1);
    run_case(300, 3, 1);
    run_case(600, 2, 1);
    run_case(256, 1, 0);
    run_case(255, 1, 1);

    // R9 results hold with ticks outside the window
    nr = 0; nf = 0;
    bus_write(8'h10, 16'h0001);
    drive_ticks(37, 2, 1, nr, nf);
    bus_write(8'h10, 16'h0000);
    begin
      int dr = 0, df = 0;
      drive_ticks(50, 1, 1, dr, df);
    end
    check_results("R9 hold", nr, nf);
    bus_read(8'h14, v);

    // R7 writes to read-only addresses ignored
    bus_write(8'h00, 16'hFFFF);
    bus_write(8'h04, 16'hFFFF);
    bus_write(8'h08, 16'hFFFF);
    bus_write(8'h0C, 16'hFFFF);
    bus_write(8'h14, 16'hFFFF);
    check_results("R7 ro", nr, nf);
    bus_read(8'h14, v); check("R7 status", v, 0);
    check("R7 irq", int'(irq), 0);

    // R8 rewrite of bit 0 mid-window neither restarts nor stops
    nr = 0; nf = 0;
    bus_write(8'h10, 16'h0001);
    drive_ticks(20, 1, 1, nr, nf);
    bus_write(8'h10, 16'h0081);
    check("R8 no irq", int'(irq), 0);
    bus_read(8'h10, v); check("R8 ctrl readback", v, 16'h0081);
    drive_ticks(15, 3, 1, nr, nf);
    bus_write(8'h10, 16'h0040);
    bus_read(8'h10, v); check("R8 ctrl after close", v, 16'h0040);
    check_results("R8 count kept", nr, nf);
    bus_read(8'h14, v); check("R8 status", v, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule